// File: doc/BRIEF.md
# Per-Branch Pattern Direction and Target Predictor

This block guesses, for a branch at a given fetch address, whether the branch will be taken and where it will go. It holds a small number of entries chosen by low address bits. Each entry remembers a tag, the last known destination, a short shift register of that branch's own recent outcomes, and its own bank of 2-bit saturating counters. The outcome history picks which counter in the bank is consulted. Because of this, a branch that follows a repeating taken/not-taken rhythm gets a counter for each position in the rhythm, and the block learns the whole pattern rather than a single bias.

The lookup side is combinational: an address goes in and a hit flag, a direction and a destination come out in the same cycle. The training side is a separate port. Once a branch resolves, its address, real direction and real destination are presented there for one cycle. A lookup and a training write in the same cycle are allowed. The lookup then reports the state as it was before that write.

Top module: `lhist_bpred`

## Requirements
- R1: After reset every lookup misses (`lkHit`=0) until a training write allocates an entry.
- R2: A lookup that misses drives `lkTaken`=0 and `lkTarget`=0; `lkTaken` is never 1 without `lkHit`.
- R3: A training write whose address misses allocates the entry. It stores the tag and the target, clears the history to 0 and sets all counters of that entry to weakly not taken. No counter is trained by the allocating write. A following lookup of that address hits, predicts not taken and returns the written target.
- R4: Each counter is 2 bits with encoding 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. A taken outcome adds one, a not-taken outcome subtracts one, and the count saturates at 00 and 11.
- R5: A hit predicts taken exactly when the selected counter's upper bit is 1 (state 10 or 11).
- R6: On a training write that hits, only the counter selected by the entry's current history is trained. The history then shifts left by one and takes the resolved outcome into bit 0 (taken = 1), dropping its oldest bit. With the default HIST_W=4 the history selects one of 16 counters.
- R7: A training write that hits and is taken replaces the stored target with the resolved target. One that hits and is not taken leaves the target unchanged.
- R8: State changes only at a clock edge with `updValid`=1. A lookup in the same cycle as a training write returns the state from before that write.
- R9: The entry index is address bits [ALIGN+IDX_W-1:ALIGN] (bits [4:2] by default) and the tag is all bits above them. A training write with the same index but a different tag replaces the resident entry, after which the old address misses.
- R10: A branch that repeats the pattern taken, taken, not taken is predicted correctly at every position once it has been trained through enough repetitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset, clears valid bits |
| lkAddr | input | ADDR_W | Address being looked up |
| lkHit | output | 1 | Lookup found a matching entry |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| lkTarget | output | ADDR_W | Predicted destination, 0 on a miss |
| updValid | input | 1 | Training write strobe |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| updTarget | input | ADDR_W | Resolved destination |

## Verification
Every cycle, the assertions check the following. A miss stays quiet and a taken prediction always comes with a hit. The address just trained hits on the next cycle, and a taken training write shows up as the new target. With no training write and a steady address, the outputs hold still. Counter saturation, which counter the history selects, the same-cycle ordering of lookup and training, alias replacement and the learning of a repeating pattern all depend on a series of writes. Only the bench's scenarios can show them, by comparing with its reference model on every clock.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;    // install a fresh entry
    logic train;    // train the hitting entry
    logic loadTgt;  // overwrite stored target
    logic outcome;  // resolved direction
  } strobe_t;

  function automatic ctr_e ctrStep(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic ctrSaysTaken(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bpred_ctrl.sv
module bpred_ctrl
  import bpred_pkg::*;
(
  input  logic    updValid,
  input  logic    updHit,
  input  logic    updTaken,
  output strobe_t stb
);

  always_comb begin
    stb         = '0;
    stb.outcome = updTaken;
    if (updValid) begin
      if (updHit) begin
        stb.train   = 1'b1;
        stb.loadTgt = updTaken;
      end else begin
        stb.alloc = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bpred_data.sv
module bpred_data
  import bpred_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 4,
  parameter int ALIGN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic              lkTaken,
  output logic [ADDR_W-1:0] lkTarget,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  strobe_t           stb,
  output logic              updHit
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN;
  localparam int NCTR  = 1 << HIST_W;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagMem  [ENTRIES];
  logic [ADDR_W-1:0]  tgtMem  [ENTRIES];
  logic [HIST_W-1:0]  histMem [ENTRIES];
  ctr_e               ctrMem  [ENTRIES][NCTR];

  logic [IDX_W-1:0] lkIdx, uIdx;
  logic [TAG_W-1:0] lkTag, uTag;

  assign lkIdx = lkAddr[ALIGN +: IDX_W];
  assign lkTag = lkAddr[ADDR_W-1 -: TAG_W];
  assign uIdx  = updAddr[ALIGN +: IDX_W];
  assign uTag  = updAddr[ADDR_W-1 -: TAG_W];

  // lookup path, reads current (pre-write) state
  always_comb begin
    lkHit    = validQ[lkIdx] && (tagMem[lkIdx] == lkTag);
    lkTaken  = lkHit && ctrSaysTaken(ctrMem[lkIdx][histMem[lkIdx]]);
    lkTarget = lkHit ? tgtMem[lkIdx] : '0;
  end

  assign updHit = validQ[uIdx] && (tagMem[uIdx] == uTag);

  // per-entry storage
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = (uIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                validQ[e] <= 1'b0;
      else if (stb.alloc && sel) validQ[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel && stb.alloc) begin
        tagMem[e]  <= uTag;
        tgtMem[e]  <= updTarget;
        histMem[e] <= '0;
        for (int c = 0; c < NCTR; c++) ctrMem[e][c] <= CTR_WNT;
      end else if (sel && stb.train) begin
        ctrMem[e][histMem[e]] <= ctrStep(ctrMem[e][histMem[e]], stb.outcome);
        histMem[e] <= (histMem[e] << 1) | HIST_W'(stb.outcome);
        if (stb.loadTgt) tgtMem[e] <= updTarget;
      end
    end
  end

endmodule

// File: rtl/lhist_bpred.sv
module lhist_bpred
  import bpred_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 4,
  parameter int ALIGN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic              lkTaken,
  output logic [ADDR_W-1:0] lkTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget
);

  strobe_t stb;
  logic    updHit;

  bpred_ctrl u_ctrl (
    .updValid (updValid),
    .updHit   (updHit),
    .updTaken (updTaken),
    .stb      (stb)
  );

  bpred_data #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .HIST_W  (HIST_W),
    .ALIGN   (ALIGN)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .lkAddr    (lkAddr),
    .lkHit     (lkHit),
    .lkTaken   (lkTaken),
    .lkTarget  (lkTarget),
    .updAddr   (updAddr),
    .updTarget (updTarget),
    .stb       (stb),
    .updHit    (updHit)
  );

endmodule

// File: rtl/lhist_bpred_chk.sv
module lhist_bpred_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic              lkTaken,
  input logic [ADDR_W-1:0] lkTarget,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic              updTaken,
  input logic [ADDR_W-1:0] updTarget
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (!lkTaken && lkTarget == '0));

  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkTaken |-> lkHit);

  // R3
  trained_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(updValid) && lkAddr == $past(updAddr)) |-> lkHit);

  // R7
  taken_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(updValid) && $past(updTaken) && lkAddr == $past(updAddr))
      |-> (lkTarget == $past(updTarget)));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(updValid) && $stable(lkAddr))
      |-> ($stable(lkHit) && $stable(lkTaken) && $stable(lkTarget)));

endmodule

bind lhist_bpred lhist_bpred_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lkAddr    (lkAddr),
  .lkHit     (lkHit),
  .lkTaken   (lkTaken),
  .lkTarget  (lkTarget),
  .updValid  (updValid),
  .updAddr   (updAddr),
  .updTaken  (updTaken),
  .updTarget (updTarget)
);

// File: tb/sim_lhist_bpred.sv
module sim_lhist_bpred;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 0;
  logic          rstN = 0;
  logic [AW-1:0] lkAddr = '0;
  logic          lkHit, lkTaken;
  logic [AW-1:0] lkTarget;
  logic          updValid = 0;
  logic [AW-1:0] updAddr = '0;
  logic          updTaken = 0;
  logic [AW-1:0] updTarget = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lhist_bpred u0 (
    .clk(clk), .rstN(rstN), .lkAddr(lkAddr), .lkHit(lkHit), .lkTaken(lkTaken),
    .lkTarget(lkTarget), .updValid(updValid), .updAddr(updAddr),
    .updTaken(updTaken), .updTarget(updTarget)
  );

  // behavioural reference model, 8 entries, index bits [4:2]
  bit          mV   [8];
  int unsigned mTag [8];
  logic [31:0] mTgt [8];
  int          mHist[8];
  int          mCtr [8][16];

  function automatic int ix(input logic [31:0] a); return int'((a >> 2) & 32'd7); endfunction
  function automatic int unsigned tg(input logic [31:0] a); return int'(a >> 5); endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // one cycle: drive, compare with model before the edge, then advance model
  task automatic cyc(input logic [31:0] la, input bit uv, input logic [31:0] ua,
                     input bit ut, input logic [31:0] ut_tgt, input string rq);
    int i, j, c;
    bit eh, et;
    logic [31:0] eg;
    @(negedge clk);
    lkAddr = la; updValid = uv; updAddr = ua; updTaken = ut; updTarget = ut_tgt;
    #1;
    i  = ix(la);
    eh = mV[i] && mTag[i] == tg(la);
    et = eh && mCtr[i][mHist[i]] >= 2;
    eg = eh ? mTgt[i] : 32'd0;
    check(lkHit == eh && lkTaken == et && lkTarget == eg, rq,
          {lkHit, lkTaken, 30'd0, lkTarget}, {eh, et, 30'd0, eg});
    @(posedge clk);
    if (uv) begin
      j = ix(ua);
      if (mV[j] && mTag[j] == tg(ua)) begin
        c = mCtr[j][mHist[j]];
        mCtr[j][mHist[j]] = ut ? ((c < 3) ? c + 1 : 3) : ((c > 0) ? c - 1 : 0);
        mHist[j] = ((mHist[j] << 1) | int'(ut)) & 15;
        if (ut) mTgt[j] = ut_tgt;
      end else begin
        mV[j] = 1; mTag[j] = tg(ua); mTgt[j] = ut_tgt; mHist[j] = 0;
        for (int k = 0; k < 16; k++) mCtr[j][k] = 1;
      end
    end
  endtask

  // idle lookup with literal expectations (plus the model comparison)
  task automatic probe(input logic [31:0] a, input bit eh, input bit et,
                       input logic [31:0] eg, input string rq);
    cyc(a, 0, 0, 0, 0, rq);
    @(negedge clk);
    lkAddr = a; updValid = 0;
    #1;
    check(lkHit == eh && lkTaken == et && (!eh || lkTarget == eg), rq,
          {lkHit, lkTaken, 30'd0, lkTarget}, {eh, et, 30'd0, eg});
  endtask

  localparam logic [31:0] A  = 32'h0000_1004;
  localparam logic [31:0] B  = 32'h0000_2008;
  localparam logic [31:0] P  = 32'h0000_300C;
  localparam logic [31:0] AL = A + 32'h0000_0020 * 8; // same index as A, other tag

  initial begin
    for (int k = 0; k < 8; k++) mV[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: everything misses after reset
    probe(A, 0, 0, 0, "R1");
    probe(B, 0, 0, 0, "R1");
    // R2: miss is quiet
    cyc(P, 0, 0, 0, 0, "R2");

    // R3: allocation
    cyc(B, 1, A, 1, 32'hAAAA_0000, "R3");
    probe(A, 1, 0, 32'hAAAA_0000, "R3");

    // R4/R5/R6: always taken saturates counter at history 1111
    for (int n = 0; n < 10; n++) cyc(A, 1, A, 1, 32'hAAAA_0000, "R4");
    probe(A, 1, 1, 32'hAAAA_0000, "R5");
    // one not-taken: ST -> WT at 1111, history becomes 1110 (untrained, weakly not taken)
    cyc(A, 1, A, 0, 32'h0, "R4");
    probe(A, 1, 0, 32'hAAAA_0000, "R6");
    // four taken bring history back to 1111, whose counter is still weakly taken
    for (int n = 0; n < 4; n++) cyc(A, 1, A, 1, 32'hAAAA_0000, "R6");
    probe(A, 1, 1, 32'hAAAA_0000, "R4");

    // R7: not-taken keeps target, taken replaces it
    cyc(A, 1, A, 0, 32'hDEAD_0000, "R7");
    probe(A, 1, lkTaken, 32'hAAAA_0000, "R7");
    cyc(A, 1, A, 1, 32'hBEEF_0000, "R7");
    probe(A, 1, lkTaken, 32'hBEEF_0000, "R7");

    // R8: same-cycle lookup sees pre-write state (first write to B allocates)
    cyc(B, 1, B, 1, 32'hBBBB_0000, "R8");
    probe(B, 1, 0, 32'hBBBB_0000, "R8");

    // R10: pattern T,T,N
    for (int n = 0; n < 30; n++) begin
      cyc(P, 1, P, 1, 32'h5555_0000, "R10");
      cyc(P, 1, P, 1, 32'h5555_0000, "R10");
      cyc(P, 1, P, 0, 32'h5555_0000, "R10");
    end
    for (int n = 0; n < 2; n++) begin
      cyc(P, 1, P, 1, 32'h5555_0000, "R10");
      check(lkTaken == 1, "R10", lkTaken, 1);
      cyc(P, 1, P, 1, 32'h5555_0000, "R10");
      check(lkTaken == 1, "R10", lkTaken, 1);
      cyc(P, 1, P, 0, 32'h5555_0000, "R10");
      check(lkTaken == 0, "R10", lkTaken, 0);
    end

    // R9: alias replaces entry
    cyc(AL, 1, AL, 1, 32'h7777_0000, "R9");
    probe(A, 0, 0, 0, "R9");
    probe(AL, 1, 0, 32'h7777_0000, "R9");
    probe(B, 1, 0, 32'hBBBB_0000, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule